// File: doc/BRIEF.md
# Byte Transceiver with Parity Generate and Check

This block joins two byte-wide bidirectional ports, A and B, and steers data through in one direction at a time. A direction input picks which port receives and which port is driven. An active-low enable can release every driven pin at once. A mode input picks the parity polarity, even or odd, while the block runs.

When data moves from A to B, the block computes a parity bit over the A byte and drives it onto a shared parity pin. When data moves from B to A, the same pin becomes an input. The block then checks that parity bit against the B byte and reports the result on an active-low error pin.

Every pad is split into an input value, an output value and an output enable, so the block stays synthesizable. The enclosing pad ring owns the tri-state buffers. The block holds no state, so every result is a function of the inputs present at that moment.

Top module: `par_xcvr`

## Requirements
- R1: With `dir_i`=1 and `oe_ni`=0, `b_oe_o`=1, `a_oe_o`=0 and `b_o` equals `a_i`.
- R2: With `dir_i`=0 and `oe_ni`=0, `a_oe_o`=1, `b_oe_o`=0 and `a_o` equals `b_i`.
- R3: With `oe_ni`=1, `a_oe_o`, `b_oe_o`, `par_oe_o` and `err_oe_o` are all 0 whatever `dir_i` is. Output values are then unspecified.
- R4: With `dir_i`=1, `oe_ni`=0 and `odd_i`=0 (even), `par_oe_o`=1 and `par_o` is 1 exactly when `a_i` holds an odd number of ones. For example, 8'b10101011 gives 1 and 8'b10101010 gives 0.
- R5: With `odd_i`=1 under the conditions of R4, `par_o` is the inverse of the even-mode value. For example, 8'b10101011 gives 0 and 8'b10101010 gives 1.
- R6: With `dir_i`=0, `oe_ni`=0 and `odd_i`=0, `err_no` is 1 exactly when `b_i` and `par_i` together hold an even number of ones. For example, `b_i`=8'b00000001 gives 1 with `par_i`=1 and 0 with `par_i`=0.
- R7: With `dir_i`=0, `oe_ni`=0 and `odd_i`=1, `err_no` is 1 exactly when `b_i` and `par_i` together hold an odd number of ones. For example, 8'b00000001 gives 0 with `par_i`=1 and 1 with `par_i`=0.
- R8: With `dir_i`=0, `par_oe_o`=0, so the parity pin is an input. With `dir_i`=1, `par_i` has no effect on `par_o`, `err_no` or any enable.
- R9: With `dir_i`=1 and `oe_ni`=0, `err_no` is driven to 1 (no error).
- R10: `err_oe_o` is 1 exactly when `oe_ni`=0, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_i | input | 1 | 1: A to B, 0: B to A |
| oe_ni | input | 1 | Active-low enable for all driven pins |
| odd_i | input | 1 | Parity polarity: 0 even, 1 odd |
| a_i | input | WIDTH | A pad input value |
| a_o | output | WIDTH | A pad output value |
| a_oe_o | output | 1 | A pad output enable |
| b_i | input | WIDTH | B pad input value |
| b_o | output | WIDTH | B pad output value |
| b_oe_o | output | 1 | B pad output enable |
| par_i | input | 1 | Parity pad input value |
| par_o | output | 1 | Parity pad output value |
| par_oe_o | output | 1 | Parity pad output enable |
| err_no | output | 1 | Active-low parity error |
| err_oe_o | output | 1 | Error pad output enable |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench applies each input combination just after a rising clock edge and samples all outputs at the following falling edge. This leaves half a period for the logic to settle, and no check depends on the order in which processes run at an edge. The sweep covers every byte value under every combination of direction, enable, mode and parity input, with a different byte on the other port so that the two ports cannot be confused.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;
  typedef enum logic {
    XFER_B2A = 1'b0,
    XFER_A2B = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;
endpackage

// File: rtl/par_xcvr_ctrl.sv
module par_xcvr_ctrl
  import par_xcvr_pkg::*;
(
  input  logic dir_i,
  input  logic oe_ni,
  output logic a_oe_o,
  output logic b_oe_o,
  output logic par_oe_o,
  output logic err_oe_o
);
  xfer_dir_e dir;
  logic      en;

  assign dir = xfer_dir_e'(dir_i);
  assign en  = ~oe_ni;

  always_comb begin
    a_oe_o   = 1'b0;
    b_oe_o   = 1'b0;
    par_oe_o = 1'b0;
    err_oe_o = en;
    if (en) begin
      unique case (dir)
        XFER_A2B: begin
          b_oe_o   = 1'b1;
          par_oe_o = 1'b1;
        end
        XFER_B2A: a_oe_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/par_xcvr_xor_tree.sv
module par_xcvr_xor_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] d_i,
  output logic             x_o
);
  localparam int LVLS = $clog2(WIDTH);
  localparam int PADW = 1 << LVLS;

  if (WIDTH < 2) begin : g_bad_width
    initial $error("par_xcvr_xor_tree: WIDTH must be at least 2");
  end

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    logic [(PADW>>l)-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < PADW; j++) begin : g_bit
        if (j < WIDTH) begin : g_in
          assign v[j] = d_i[j];
        end else begin : g_pad
          assign v[j] = 1'b0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < (PADW >> l); j++) begin : g_bit
        assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
      end
    end
  end

  assign x_o = g_lvl[LVLS].v[0];
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
  import par_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_i,
  input  logic             oe_ni,
  input  logic             odd_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             err_no,
  output logic             err_oe_o
);
  logic a_sum, b_sum;

  par_xcvr_ctrl u_ctrl (
    .dir_i   (dir_i),
    .oe_ni   (oe_ni),
    .a_oe_o  (a_oe_o),
    .b_oe_o  (b_oe_o),
    .par_oe_o(par_oe_o),
    .err_oe_o(err_oe_o)
  );

  par_xcvr_xor_tree #(.WIDTH(WIDTH)) u_gen (
    .d_i(a_i),
    .x_o(a_sum)
  );

  par_xcvr_xor_tree #(.WIDTH(WIDTH)) u_chk_tree (
    .d_i(b_i),
    .x_o(b_sum)
  );

  // data paths are unconditional; the enables decide what reaches the pads
  assign b_o   = a_i;
  assign a_o   = b_i;
  assign par_o = a_sum ^ odd_i;

  always_comb begin
    if (xfer_dir_e'(dir_i) == XFER_A2B) err_no = 1'b1;
    else                                err_no = ~(b_sum ^ par_i ^ odd_i);
  end
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             dir_i,
  input logic             oe_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o,
  input logic             par_oe_o,
  input logic             err_no,
  input logic             err_oe_o
);
  always_comb begin
    a_r3_all_released: assert (!oe_ni || !(a_oe_o || b_oe_o || par_oe_o || err_oe_o));
    a_r1_one_driver: assert ($onehot0({a_oe_o, b_oe_o}));
    a_r1_b_follows_a: assert (!b_oe_o || b_o == a_i);
    a_r2_a_follows_b: assert (!a_oe_o || a_o == b_i);
    a_r8_par_with_b: assert (!par_oe_o || b_oe_o);
    a_r9_no_err_on_send: assert (!par_oe_o || err_no);
    a_r10_err_oe_tracks: assert (err_oe_o == (a_oe_o || b_oe_o));
    a_r2_dir_a_dest: assert (!a_oe_o || !dir_i);
  end
endmodule

bind par_xcvr par_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .dir_i   (dir_i),
  .oe_ni   (oe_ni),
  .a_i     (a_i),
  .a_o     (a_o),
  .a_oe_o  (a_oe_o),
  .b_i     (b_i),
  .b_o     (b_o),
  .b_oe_o  (b_oe_o),
  .par_oe_o(par_oe_o),
  .err_no  (err_no),
  .err_oe_o(err_oe_o)
);

// File: tb/par_xcvr_test.sv
`timescale 1ns/1ps
module par_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         dir, oe_n, odd, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_n, err_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  par_xcvr #(.WIDTH(W)) uut (
    .dir_i(dir), .oe_ni(oe_n), .odd_i(odd),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe),
    .par_i(par_in), .par_o(par_out), .par_oe_o(par_oe),
    .err_no(err_n), .err_oe_o(err_oe)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (dir=%0b oe_n=%0b odd=%0b a=%02h b=%02h par_i=%0b)",
               req, what, act, exp, dir, oe_n, odd, a_in, b_in, par_in);
    end
  endtask

  task automatic apply(input logic d, input logic e, input logic o,
                       input logic [W-1:0] av, input logic [W-1:0] bv, input logic p);
    @(posedge clk);
    dir = d; oe_n = e; odd = o; a_in = av; b_in = bv; par_in = p;
    @(negedge clk);
  endtask

  // full expected-value check for the current stimulus
  task automatic check_all();
    logic exp_par, exp_err;
    exp_par = ((ones(a_in) % 2) == 1) ^ odd;
    exp_err = (((ones(b_in) + int'(par_in)) % 2) == 0) ^ odd;
    chk("R10", "err_oe", err_oe, !oe_n);
    if (oe_n) begin
      chk("R3", "a_oe", a_oe, 0);
      chk("R3", "b_oe", b_oe, 0);
      chk("R3", "par_oe", par_oe, 0);
      chk("R3", "err_oe", err_oe, 0);
    end else if (dir) begin
      chk("R1", "b_oe", b_oe, 1);
      chk("R1", "a_oe", a_oe, 0);
      chk("R1", "b_o", b_out, a_in);
      chk("R4", "par_oe", par_oe, 1);
      chk(odd ? "R5" : "R4", "par_o", par_out, exp_par);
      chk("R9", "err_n", err_n, 1);
    end else begin
      chk("R2", "a_oe", a_oe, 1);
      chk("R2", "b_oe", b_oe, 0);
      chk("R2", "a_o", a_out, b_in);
      chk("R8", "par_oe", par_oe, 0);
      chk(odd ? "R7" : "R6", "err_n", err_n, exp_err);
    end
  endtask

  initial begin
    dir = 1'b1; oe_n = 1'b1; odd = 1'b0; a_in = '0; b_in = '0; par_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // released state
    @(negedge clk);
    chk("R3", "a_oe", a_oe, 0);
    chk("R3", "b_oe", b_oe, 0);
    chk("R3", "par_oe", par_oe, 0);
    chk("R10", "err_oe", err_oe, 0);

    // spot examples
    apply(1, 0, 0, 8'b10101011, 8'h00, 0); chk("R4", "par 10101011 even", par_out, 1);
    apply(1, 0, 0, 8'b10101010, 8'h00, 0); chk("R4", "par 10101010 even", par_out, 0);
    apply(1, 0, 1, 8'b10101011, 8'h00, 0); chk("R5", "par 10101011 odd", par_out, 0);
    apply(1, 0, 1, 8'b10101010, 8'h00, 0); chk("R5", "par 10101010 odd", par_out, 1);
    apply(0, 0, 0, 8'h00, 8'b00000001, 1); chk("R6", "err even p1", err_n, 1);
    apply(0, 0, 0, 8'h00, 8'b00000001, 0); chk("R6", "err even p0", err_n, 0);
    apply(0, 0, 1, 8'h00, 8'b00000001, 1); chk("R7", "err odd p1", err_n, 0);
    apply(0, 0, 1, 8'h00, 8'b00000001, 0); chk("R7", "err odd p0", err_n, 1);

    // R8: par_i must not move anything in A-to-B mode
    for (int v = 0; v < 256; v += 37) begin
      logic p0, e0, q0;
      apply(1, 0, 0, W'(v), ~W'(v), 0);
      p0 = par_out; e0 = err_n; q0 = par_oe;
      apply(1, 0, 0, W'(v), ~W'(v), 1);
      chk("R8", "par_o vs par_i", par_out, p0);
      chk("R8", "err_n vs par_i", err_n, e0);
      chk("R8", "par_oe vs par_i", par_oe, q0);
    end

    // exhaustive sweep
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 2; p++)
            for (int v = 0; v < 256; v++) begin
              apply(d[0], e[0], o[0], W'(v), W'(v) ^ 8'h5a, p[0]);
              check_all();
              apply(d[0], e[0], o[0], W'(v) ^ 8'hc3, W'(v), p[0]);
              check_all();
            end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule